// File: doc/BRIEF.md
# Four-Way Line Code Encoder and Decoder

This block sits between a serial bit stream and the physical line. It encodes each transmit bit into line levels and decodes each received cell back into a bit. A 2-bit select chooses one of four codes: plain level coding (NRZ), transition-on-zero coding (NRZI), or one of two biphase codes. FM1 marks a one with a mid-cell transition. FM0 marks a zero with a mid-cell transition. The transmit path and the receive path always use the same code.

Bit timing comes from outside. A `bit_stb` pulse marks the start of each cell, and a `half_stb` pulse marks its middle. The biphase codes use both pulses; the level codes act only on `bit_stb`. The select is captured at a cell boundary and then held for the whole cell. The receive side samples the line at mid-cell and again at the end of the cell, and it reports the bit of each completed cell one clock after the closing boundary.

Top module: `line_codec`

## Requirements
- R1: After reset the active code is NRZ (select value 00), `tx_line` is 0 and `rx_valid` is 0. Before the first `bit_stb`, a `half_stb` leaves `tx_line` unchanged whatever the select input holds.
- R2: With select 00 (NRZ), in the clock after a `bit_stb` edge `tx_line` equals the `tx_data` value sampled at that edge, and it holds that value through the cell.
- R3: With select 01 (NRZI), at a `bit_stb` edge the line toggles when `tx_data` is 0 and holds when it is 1. `half_stb` has no effect on the line.
- R4: With select 10 (FM1) or 11 (FM0), the line toggles at every `bit_stb` edge, whatever the data bit.
- R5: With select 10 (FM1), the line toggles at the `half_stb` edge when the cell's bit is 1, and holds when it is 0.
- R6: With select 11 (FM0), the line toggles at the `half_stb` edge when the cell's bit is 0, and holds when it is 1.
- R7: At each `bit_stb` edge after the first one following reset, the decoder registers the bit of the cell that just ended. It raises `rx_valid` for exactly one clock, and `rx_data` holds that bit. At the first `bit_stb` after reset, `rx_valid` stays 0.
- R8: The select is taken only at a `bit_stb` edge. A change of `mode_sel` inside a cell does not alter that cell's mid-cell behaviour or its decoding.
- R9: `tx_line` changes only at an edge where `bit_stb` or `half_stb` is high.
- R10: The decoder rules are as follows. NRZ returns the line level at the end of the cell. NRZI returns 1 when the end-of-cell level equals the previous end-of-cell level. FM1 returns 1 when the mid-cell sample differs from the end-of-cell sample. FM0 returns 1 when the two samples are equal. With `rx_line` looped back from `tx_line`, every cell decodes to the bit that was sent, including cells on either side of a change of code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 FM1, 11 FM0 |
| bit_stb | input | 1 | One-clock pulse at the start of each bit cell |
| half_stb | input | 1 | One-clock pulse at the middle of each bit cell |
| tx_data | input | 1 | Transmit data bit, sampled at `bit_stb` |
| tx_line | output | 1 | Encoded line level |
| rx_line | input | 1 | Received line level |
| rx_data | output | 1 | Decoded bit of the last completed cell |
| rx_valid | output | 1 | One-clock pulse when `rx_data` is updated |

## Verification
The hardest case to reach is a select change in the middle of a cell. The encoder must keep the code latched at the cell start for its mid-cell action, and the decoder must judge that same cell by the code in force when it began. The bench reaches this by moving `mode_sel` to a different biphase polarity between `bit_stb` and `half_stb`, with the line looped back into the receiver. It then checks the mid-cell level, the decoded bit at the next boundary, and the new code in the following cell. A second case is reached by swapping between level and biphase codes on consecutive cells. That checks that the decoder's previous-level history survives the swap.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LC_NRZ  = 2'b00,
    LC_NRZI = 2'b01,
    LC_FM1  = 2'b10,
    LC_FM0  = 2'b11
  } lc_mode_e;

  // Line level right after a cell boundary.
  function automatic logic enc_start(lc_mode_e m, logic d, logic cur);
    logic nxt;
    case (m)
      LC_NRZ:  nxt = d;
      LC_NRZI: nxt = d ? cur : ~cur;
      default: nxt = ~cur;
    endcase
    return nxt;
  endfunction

  // Line level right after mid-cell.
  function automatic logic enc_mid(lc_mode_e m, logic d, logic cur);
    logic nxt;
    case (m)
      LC_FM1:  nxt = d ? ~cur : cur;
      LC_FM0:  nxt = d ? cur : ~cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  // Bit recovered from the samples of one completed cell.
  function automatic logic dec_bit(lc_mode_e m, logic end_lvl,
                                   logic mid_lvl, logic prev_end);
    logic b;
    case (m)
      LC_NRZ:  b = end_lvl;
      LC_NRZI: b = (end_lvl == prev_end);
      LC_FM1:  b = (mid_lvl != end_lvl);
      default: b = (mid_lvl == end_lvl);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lc_mode_reg.sv
module lc_mode_reg
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic [MODE_W-1:0] mode_sel,
  output lc_mode_e          cell_mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cell_mode <= LC_NRZ;
    else if (bit_stb) cell_mode <= lc_mode_e'(mode_sel);
  end

endmodule

// File: rtl/lc_encoder.sv
module lc_encoder
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              half_stb,
  input  logic [MODE_W-1:0] mode_sel,
  input  lc_mode_e          cell_mode,
  input  logic              tx_data,
  output logic              tx_line
);

  logic cell_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_line  <= 1'b0;
      cell_bit <= 1'b0;
    end else if (bit_stb) begin
      cell_bit <= tx_data;
      tx_line  <= enc_start(lc_mode_e'(mode_sel), tx_data, tx_line);
    end else if (half_stb) begin
      tx_line  <= enc_mid(cell_mode, cell_bit, tx_line);
    end
  end

endmodule

// File: rtl/lc_decoder.sv
module lc_decoder
  import lc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_stb,
  input  logic     half_stb,
  input  lc_mode_e cell_mode,
  input  logic     rx_line,
  output logic     rx_data,
  output logic     rx_valid
);

  logic mid_lvl;
  logic prev_end;
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_lvl  <= 1'b0;
      prev_end <= 1'b0;
      primed   <= 1'b0;
      rx_data  <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (half_stb) mid_lvl <= rx_line;
      if (bit_stb) begin
        prev_end <= rx_line;
        primed   <= 1'b1;
        if (primed) begin
          rx_data  <= dec_bit(cell_mode, rx_line, mid_lvl, prev_end);
          rx_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/line_codec.sv
module line_codec
  import lc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       bit_stb,
  input  logic       half_stb,
  input  logic       tx_data,
  output logic       tx_line,
  input  logic       rx_line,
  output logic       rx_data,
  output logic       rx_valid
);

  lc_mode_e cell_mode;

  lc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .mode_sel(mode_sel), .cell_mode(cell_mode)
  );

  lc_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .half_stb(half_stb),
    .mode_sel(mode_sel), .cell_mode(cell_mode), .tx_data(tx_data),
    .tx_line(tx_line)
  );

  lc_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .half_stb(half_stb),
    .cell_mode(cell_mode), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic       half_stb,
  input logic       tx_data,
  input logic       tx_line,
  input logic       rx_valid,
  input logic [1:0] cell_mode
);

  a_r2_nrz_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_stb) && cell_mode == 2'b00) |-> (tx_line == $past(tx_data)));

  a_r3_nrzi_hold_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_stb) && cell_mode == 2'b01 && $past(tx_data))
      |-> (tx_line == $past(tx_line)));

  a_r4_fm_start_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_stb) && cell_mode[1]) |-> (tx_line != $past(tx_line)));

  a_r7_valid_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_stb));

  a_r8_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_mode != $past(cell_mode)) |-> $past(bit_stb));

  a_r9_line_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line != $past(tx_line)) |-> ($past(bit_stb) || $past(half_stb)));

endmodule

bind line_codec lc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .half_stb(half_stb),
  .tx_data(tx_data), .tx_line(tx_line), .rx_valid(rx_valid),
  .cell_mode(cell_mode)
);

// File: tb/sim_line_codec.sv
`timescale 1ns/1ps
module sim_line_codec;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic bit_stb = 1'b0, half_stb = 1'b0, tx_data = 1'b0;
  logic tx_line, rx_line, rx_data, rx_valid;

  int checks = 0;
  int errors = 0;

  // model state
  logic line_m = 1'b0;
  logic have_prev = 1'b0;
  logic prev_bit = 1'b0;

  assign rx_line = tx_line;
  always #4 clk = ~clk;

  line_codec u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bit_stb(bit_stb),
    .half_stb(half_stb), .tx_data(tx_data), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One full cell: boundary, mid-cell, idle. mid_m is driven on mode_sel
  // after the boundary to show it has no effect inside the cell.
  task automatic send_bit(input logic [1:0] m, input logic d,
                          input logic [1:0] mid_m, input string req);
    logic e1, e2;
    @(negedge clk);
    mode_sel = m; tx_data = d; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    mode_sel = mid_m;
    tx_data = ~d;
    if (have_prev) begin
      check("R7 valid pulse", rx_valid, 1'b1);
      check({"R10 decode ", req}, rx_data, prev_bit);
    end else begin
      check("R7 no valid on first boundary", rx_valid, 1'b0);
    end
    if (m == 2'b00)      e1 = d;
    else if (m == 2'b01) e1 = line_m ^ ~d;
    else                 e1 = ~line_m;
    check({req, " start level"}, tx_line, e1);
    @(negedge clk);
    half_stb = 1'b1;
    @(negedge clk);
    half_stb = 1'b0;
    if (m[1]) e2 = e1 ^ (d ^ m[0]);
    else      e2 = e1;
    check({req, " mid level"}, tx_line, e2);
    @(negedge clk);
    check("R7 valid one clock only", rx_valid, 1'b0);
    check("R9 line steady off strobe", tx_line, e2);
    line_m = e2;
    have_prev = 1'b1;
    prev_bit = d;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset line", tx_line, 1'b0);
    check("R1 reset valid", rx_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    mode_sel = 2'b10; tx_data = 1'b1; half_stb = 1'b1;
    @(negedge clk);
    half_stb = 1'b0;
    check("R1 reset code is NRZ (mid strobe ignored)", tx_line, 1'b0);
    line_m = 1'b0; have_prev = 1'b0;
  endtask

  task automatic test_nrz();
    send_bit(2'b00, 1'b1, 2'b00, "R2 NRZ");
    send_bit(2'b00, 1'b0, 2'b00, "R2 NRZ");
    send_bit(2'b00, 1'b1, 2'b00, "R2 NRZ");
    send_bit(2'b00, 1'b1, 2'b00, "R2 NRZ");
  endtask

  task automatic test_nrzi();
    send_bit(2'b01, 1'b0, 2'b01, "R3 NRZI");
    send_bit(2'b01, 1'b0, 2'b01, "R3 NRZI");
    send_bit(2'b01, 1'b1, 2'b01, "R3 NRZI");
    send_bit(2'b01, 1'b0, 2'b01, "R3 NRZI");
    send_bit(2'b01, 1'b1, 2'b01, "R3 NRZI");
  endtask

  task automatic test_fm1();
    send_bit(2'b10, 1'b1, 2'b10, "R4 R5 FM1");
    send_bit(2'b10, 1'b0, 2'b10, "R4 R5 FM1");
    send_bit(2'b10, 1'b0, 2'b10, "R4 R5 FM1");
    send_bit(2'b10, 1'b1, 2'b10, "R4 R5 FM1");
  endtask

  task automatic test_fm0();
    send_bit(2'b11, 1'b0, 2'b11, "R4 R6 FM0");
    send_bit(2'b11, 1'b1, 2'b11, "R4 R6 FM0");
    send_bit(2'b11, 1'b1, 2'b11, "R4 R6 FM0");
    send_bit(2'b11, 1'b0, 2'b11, "R4 R6 FM0");
  endtask

  task automatic test_mid_cell_switch();
    send_bit(2'b10, 1'b1, 2'b11, "R8 FM1 cell, select moved to FM0");
    send_bit(2'b11, 1'b1, 2'b10, "R8 FM0 cell, select moved to FM1");
    send_bit(2'b00, 1'b0, 2'b11, "R8 NRZ cell, select moved to FM0");
    send_bit(2'b01, 1'b1, 2'b10, "R8 NRZI cell, select moved to FM1");
    send_bit(2'b11, 1'b0, 2'b01, "R10 FM0 after NRZI");
    send_bit(2'b01, 1'b0, 2'b00, "R10 NRZI after FM0");
    send_bit(2'b00, 1'b1, 2'b00, "R10 NRZ closing cell");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_nrz();
    test_nrzi();
    test_fm1();
    test_fm0();
    test_mid_cell_switch();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule